// File: doc/BRIEF.md
# Deferred-Payload Link CRC Generator and Checker

This block protects a flit-based point-to-point link with a 25-bit CRC. The CRC field of a header flit does not cover the data flits that follow that header. It covers the header itself, followed by the data flits of the transaction sent before it. A transaction is one header flit followed by up to two 128-bit data flits, so at most 32 bytes of payload. The previous transaction's payload therefore has to be kept until the next header passes. After the first header following reset, the previous transaction counts as empty.

The transmit side takes a stream of flits. Each flit has a valid strobe, a start-of-packet marker and a header/data type bit. The block forwards every flit one cycle later and writes the computed CRC into bits [24:0] of each header. The receive side keeps its own copy of the previous payload and computes the CRC for every incoming header. When the value carried in the header differs from the computed one, it raises a one-cycle error pulse. Both sides share the same rules for keeping and clearing payload. A synchronous reset returns both sides to the empty-previous-transaction state.

Top module: `lagged_crc_link`

## Requirements
- R1: While reset is high and in the cycle after it, tx_valid_o, tx_sop_o, tx_hdr_o and rx_crc_error_o are 0 and tx_flit_o is all zero. The first header after reset gets a CRC computed over that header alone.
- R2: A transmit header (tx_valid_i=1, tx_hdr_i=1) appears on tx_flit_o one cycle later. Bits [127:25] are unchanged. Bits [24:0] hold the CRC of the message formed by the header (with its bits [24:0] taken as zero) followed by the kept payload flits of the previous transaction, in the order they were sent.
- R3: The CRC is defined as follows. Each flit is fed from bit 127 down to bit 0. The seed is zero and there is no final inversion. The result is the remainder of message·x^25 divided by x^25+x^2+x+1.
- R4: The incoming contents of a transmit header's bits [24:0] have no effect on the CRC placed in the output.
- R5: A data flit (tx_valid_i=1, tx_hdr_i=0) is forwarded unchanged one cycle later. tx_valid_o and tx_hdr_o follow their inputs with the same one-cycle latency. tx_sop_o equals tx_sop_i of the same flit.
- R6: Only the first two data flits after a header are kept. Any further data flit in the same transaction leaves the next header's CRC unchanged.
- R7: Each header clears the kept payload. If a transaction has no data flits, the next header's CRC covers only that next header.
- R8: On receive, rx_crc_error_o is 1 for exactly the one cycle after a header (rx_valid_i=1, rx_hdr_i=1) whose bits [24:0] differ from the CRC computed by the R2/R3 rules. It is 0 after a matching header, after a data flit and after an idle cycle.
- R9: The receive side keeps its own previous-transaction payload under the same R6/R7 rules. A header CRC that leaves out the previous payload is therefore reported as an error.
- R10: A synchronous reset in the middle of a stream returns both sides to the empty-previous-transaction state.
- R11: Idle cycles (valid low) between flits do not change the kept payload. They produce tx_valid_o=0 with an all-zero tx_flit_o one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid_i | input | 1 | Transmit flit valid |
| tx_sop_i | input | 1 | Transmit start-of-packet marker |
| tx_hdr_i | input | 1 | Transmit flit type: 1 header, 0 data |
| tx_flit_i | input | 128 | Transmit flit |
| tx_valid_o | output | 1 | Forwarded flit valid |
| tx_sop_o | output | 1 | Forwarded start-of-packet marker |
| tx_hdr_o | output | 1 | Forwarded flit type |
| tx_flit_o | output | 128 | Forwarded flit, CRC in [24:0] of headers |
| rx_valid_i | input | 1 | Receive flit valid |
| rx_hdr_i | input | 1 | Receive flit type: 1 header, 0 data |
| rx_flit_i | input | 128 | Receive flit |
| rx_crc_error_o | output | 1 | One-cycle CRC mismatch pulse |

## Verification
The transmit side is driven through every pairing of previous and current payload counts from zero to three. This separates correct carry-over from payload dropped too early, kept too long, or counted beyond two flits. Headers with random low bits and with all-ones low bits show whether the incoming field leaks into the CRC. Idle gaps placed between flits show whether idle cycles disturb the kept payload. On receive, every one of the 25 CRC bits is flipped in turn, and some headers carry a CRC that leaves out the previous payload. Resets in the middle of both streams confirm the return to the empty state.

// File: rtl/lagged_crc_pkg.sv
package lagged_crc_pkg;
    localparam int FLIT_W    = 128;
    localparam int CRC_W     = 25;
    localparam int PAY_SLOTS = 2;
    // x^25 + x^2 + x + 1, leading term implied
    localparam logic [CRC_W-1:0] CRC_POLY = 25'h0000007;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_HDR  = 1'b1
    } flit_kind_e;
endpackage

// File: rtl/lagged_crc_hold.sv
module lagged_crc_hold #(
    parameter int FLIT_W = lagged_crc_pkg::FLIT_W,
    parameter int SLOTS  = lagged_crc_pkg::PAY_SLOTS,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         valid_i,
    input  logic                         hdr_i,
    input  logic [FLIT_W-1:0]            flit_i,
    output logic [SLOTS-1:0][FLIT_W-1:0] pay_o,
    output logic [CNT_W-1:0]             cnt_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [SLOTS-1:0][FLIT_W-1:0] pay;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid_i && (hdr_i == lagged_crc_pkg::KIND_HDR)) begin
            st_d = '0;
        end else if (valid_i && st_q.cnt != FULL) begin
            for (int k = 0; k < SLOTS; k++) begin
                if (st_q.cnt == CNT_W'(k)) st_d.pay[k] = flit_i;
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pay_o = st_q.pay;
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/lagged_crc_calc.sv
module lagged_crc_calc #(
    parameter int FLIT_W = lagged_crc_pkg::FLIT_W,
    parameter int CRC_W  = lagged_crc_pkg::CRC_W,
    parameter int SLOTS  = lagged_crc_pkg::PAY_SLOTS,
    parameter int CNT_W  = $clog2(SLOTS + 1),
    parameter logic [CRC_W-1:0] POLY = lagged_crc_pkg::CRC_POLY
) (
    input  logic [FLIT_W-1:0]            hdr_i,
    input  logic [SLOTS-1:0][FLIT_W-1:0] pay_i,
    input  logic [CNT_W-1:0]             cnt_i,
    output logic [CRC_W-1:0]             crc_o
);
    function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] seed,
                                              input logic [FLIT_W-1:0] d);
        logic [CRC_W-1:0] s;
        logic             fb;
        s = seed;
        for (int i = FLIT_W - 1; i >= 0; i--) begin
            fb = s[CRC_W-1] ^ d[i];
            s  = {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return s;
    endfunction

    logic [CRC_W-1:0] stage [SLOTS+1];

    // header first, its own CRC field taken as zero
    assign stage[0] = fold('0, {hdr_i[FLIT_W-1:CRC_W], {CRC_W{1'b0}}});

    for (genvar g = 0; g < SLOTS; g++) begin : g_chain
        assign stage[g+1] = fold(stage[g], pay_i[g]);
    end

    assign crc_o = stage[cnt_i];
endmodule

// File: rtl/lagged_crc_link.sv
module lagged_crc_link #(
    parameter int FLIT_W    = lagged_crc_pkg::FLIT_W,
    parameter int CRC_W     = lagged_crc_pkg::CRC_W,
    parameter int PAY_SLOTS = lagged_crc_pkg::PAY_SLOTS,
    parameter logic [CRC_W-1:0] CRC_POLY = lagged_crc_pkg::CRC_POLY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid_i,
    input  logic              tx_sop_i,
    input  logic              tx_hdr_i,
    input  logic [FLIT_W-1:0] tx_flit_i,
    output logic              tx_valid_o,
    output logic              tx_sop_o,
    output logic              tx_hdr_o,
    output logic [FLIT_W-1:0] tx_flit_o,
    input  logic              rx_valid_i,
    input  logic              rx_hdr_i,
    input  logic [FLIT_W-1:0] rx_flit_i,
    output logic              rx_crc_error_o
);
    localparam int CNT_W = $clog2(PAY_SLOTS + 1);
    localparam int SIDES = 2;   // 0 transmit, 1 receive

    logic [SIDES-1:0]                             side_valid;
    logic [SIDES-1:0]                             side_hdr;
    logic [SIDES-1:0][FLIT_W-1:0]                 side_flit;
    logic [SIDES-1:0][CRC_W-1:0]                  side_crc;

    assign side_valid = {rx_valid_i, tx_valid_i};
    assign side_hdr   = {rx_hdr_i, tx_hdr_i};
    assign side_flit  = {rx_flit_i, tx_flit_i};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        logic [PAY_SLOTS-1:0][FLIT_W-1:0] pay;
        logic [CNT_W-1:0]                 cnt;

        lagged_crc_hold #(
            .FLIT_W (FLIT_W),
            .SLOTS  (PAY_SLOTS),
            .CNT_W  (CNT_W)
        ) u_hold (
            .clk     (clk),
            .rst     (rst),
            .valid_i (side_valid[s]),
            .hdr_i   (side_hdr[s]),
            .flit_i  (side_flit[s]),
            .pay_o   (pay),
            .cnt_o   (cnt)
        );

        lagged_crc_calc #(
            .FLIT_W (FLIT_W),
            .CRC_W  (CRC_W),
            .SLOTS  (PAY_SLOTS),
            .CNT_W  (CNT_W),
            .POLY   (CRC_POLY)
        ) u_calc (
            .hdr_i (side_flit[s]),
            .pay_i (pay),
            .cnt_i (cnt),
            .crc_o (side_crc[s])
        );
    end

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              hdr;
        logic [FLIT_W-1:0] flit;
        logic              err;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = '0;
        out_d.valid = tx_valid_i;
        if (tx_valid_i) begin
            out_d.sop  = tx_sop_i;
            out_d.hdr  = tx_hdr_i;
            out_d.flit = tx_flit_i;
            if (tx_hdr_i) out_d.flit[CRC_W-1:0] = side_crc[0];
        end
        out_d.err = rx_valid_i && rx_hdr_i &&
                    (rx_flit_i[CRC_W-1:0] != side_crc[1]);
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign tx_valid_o     = out_q.valid;
    assign tx_sop_o       = out_q.sop;
    assign tx_hdr_o       = out_q.hdr;
    assign tx_flit_o      = out_q.flit;
    assign rx_crc_error_o = out_q.err;
endmodule

// File: rtl/lagged_crc_link_chk.sv
module lagged_crc_link_chk #(
    parameter int FLIT_W = 128,
    parameter int CRC_W  = 25
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_valid_i,
    input logic              tx_hdr_i,
    input logic [FLIT_W-1:0] tx_flit_i,
    input logic              tx_valid_o,
    input logic              tx_hdr_o,
    input logic [FLIT_W-1:0] tx_flit_o,
    input logic              rx_valid_i,
    input logic              rx_hdr_i,
    input logic              rx_crc_error_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tx_valid_o && !rx_crc_error_o)); // R1

    AST_HDR_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_i && tx_hdr_i) |=>
            (tx_flit_o[FLIT_W-1:CRC_W] == $past(tx_flit_i[FLIT_W-1:CRC_W]))); // R2

    AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_i && !tx_hdr_i) |=> (tx_flit_o == $past(tx_flit_i))); // R5

    AST_TYPE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        tx_valid_i |=> (tx_valid_o && (tx_hdr_o == $past(tx_hdr_i)))); // R5

    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
        !tx_valid_i |=> (!tx_valid_o && (tx_flit_o == '0))); // R11

    AST_ERR_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        rx_crc_error_o |-> $past(rx_valid_i && rx_hdr_i)); // R8

    AST_ERR_NOT_ON_DATA: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid_i && rx_hdr_i) |=> !rx_crc_error_o); // R8
endmodule

bind lagged_crc_link lagged_crc_link_chk #(
    .FLIT_W (FLIT_W),
    .CRC_W  (CRC_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_valid_i     (tx_valid_i),
    .tx_hdr_i       (tx_hdr_i),
    .tx_flit_i      (tx_flit_i),
    .tx_valid_o     (tx_valid_o),
    .tx_hdr_o       (tx_hdr_o),
    .tx_flit_o      (tx_flit_o),
    .rx_valid_i     (rx_valid_i),
    .rx_hdr_i       (rx_hdr_i),
    .rx_crc_error_o (rx_crc_error_o)
);

// File: tb/sim_lagged_crc_link.sv
module sim_lagged_crc_link;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tx_valid_i = 1'b0, tx_sop_i = 1'b0, tx_hdr_i = 1'b0;
    logic [127:0] tx_flit_i = '0;
    logic         tx_valid_o, tx_sop_o, tx_hdr_o;
    logic [127:0] tx_flit_o;
    logic         rx_valid_i = 1'b0, rx_hdr_i = 1'b0;
    logic [127:0] rx_flit_i = '0;
    logic         rx_crc_error_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [127:0] tx_prev [2];
    int           tx_prev_n = 0;
    logic [127:0] rx_prev [2];
    int           rx_prev_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lagged_crc_link u0 (
        .clk            (clk),
        .rst            (rst),
        .tx_valid_i     (tx_valid_i),
        .tx_sop_i       (tx_sop_i),
        .tx_hdr_i       (tx_hdr_i),
        .tx_flit_i      (tx_flit_i),
        .tx_valid_o     (tx_valid_o),
        .tx_sop_o       (tx_sop_o),
        .tx_hdr_o       (tx_hdr_o),
        .tx_flit_o      (tx_flit_o),
        .rx_valid_i     (rx_valid_i),
        .rx_hdr_i       (rx_hdr_i),
        .rx_flit_i      (rx_flit_i),
        .rx_crc_error_o (rx_crc_error_o)
    );

    // Remainder of message * x^25 modulo x^25 + x^2 + x + 1 by long division
    function automatic logic [24:0] ref_crc(input logic [127:0] h,
                                            input logic [127:0] p0,
                                            input logic [127:0] p1,
                                            input int n);
        bit msg [0:408];
        int len;
        logic [24:0] r;
        len = 128 * (n + 1);
        for (int i = 0; i < 409; i++) msg[i] = 1'b0;
        for (int i = 0; i < 128; i++) begin
            msg[i] = (i >= 103) ? 1'b0 : h[127-i];
            if (n > 0) msg[128+i] = p0[127-i];
            if (n > 1) msg[256+i] = p1[127-i];
        end
        for (int i = 0; i < len; i++) begin
            if (msg[i]) begin
                msg[i]    = 1'b0;
                msg[i+23] = ~msg[i+23];
                msg[i+24] = ~msg[i+24];
                msg[i+25] = ~msg[i+25];
            end
        end
        for (int j = 0; j < 25; j++) r[24-j] = msg[len+j];
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_cycle(input string req);
        tx_valid_i = 1'b0; tx_sop_i = 1'b0; tx_hdr_i = 1'b0; tx_flit_i = rnd128();
        rx_valid_i = 1'b0; rx_hdr_i = 1'b0; rx_flit_i = rnd128();
        @(negedge clk);
        chk(!tx_valid_o && tx_flit_o == '0, req, {tx_valid_o, tx_flit_o}, '0);
        chk(!rx_crc_error_o, req, 128'(rx_crc_error_o), '0);
    endtask

    task automatic do_reset(input string req);
        tx_valid_i = 1'b0; rx_valid_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(!tx_valid_o && !tx_sop_o && !tx_hdr_o && tx_flit_o == '0 && !rx_crc_error_o,
            req, {tx_valid_o, tx_sop_o, tx_hdr_o, rx_crc_error_o, tx_flit_o[123:0]}, '0);
        rst = 1'b0;
        tx_prev_n = 0;
        rx_prev_n = 0;
    endtask

    task automatic tx_flit(input bit hdr, input logic [127:0] d,
                           input logic [127:0] exp, input string req);
        tx_valid_i = 1'b1; tx_sop_i = hdr; tx_hdr_i = hdr; tx_flit_i = d;
        @(negedge clk);
        chk(tx_valid_o && tx_hdr_o == hdr && tx_sop_o == hdr, {req, " flags"},
            {tx_valid_o, tx_hdr_o, tx_sop_o}, {1'b1, hdr, hdr});
        chk(tx_flit_o == exp, req, tx_flit_o, exp);
    endtask

    task automatic tx_txn(input int n, input bit gaps, input bit ones_low, input string req);
        logic [127:0] h, d, e;
        h = rnd128();
        if (ones_low) h[24:0] = '1;
        e = {h[127:25], ref_crc(h, tx_prev[0], tx_prev[1], tx_prev_n)};
        tx_flit(1'b1, h, e, req);
        if (gaps) idle_cycle("R11 idle gap");
        tx_prev_n = 0;
        for (int k = 0; k < n; k++) begin
            d = rnd128();
            tx_flit(1'b0, d, d, "R5 data pass");
            if (gaps) idle_cycle("R11 idle gap");
            if (k < 2) begin
                tx_prev[k] = d;
                tx_prev_n  = k + 1;
            end
        end
    endtask

    // flip < 0: no corruption; drop_pay: CRC computed as if no previous payload
    task automatic rx_txn(input int n, input int flip, input bit drop_pay, input string req);
        logic [127:0] h, d;
        logic [24:0]  good, field;
        bit           exp_err;
        h     = rnd128();
        good  = ref_crc(h, rx_prev[0], rx_prev[1], rx_prev_n);
        field = drop_pay ? ref_crc(h, '0, '0, 0) : good;
        if (flip >= 0) field[flip] = ~field[flip];
        exp_err = (field != good);
        rx_valid_i = 1'b1; rx_hdr_i = 1'b1; rx_flit_i = {h[127:25], field};
        @(negedge clk);
        chk(rx_crc_error_o == exp_err, req, 128'(rx_crc_error_o), 128'(exp_err));
        rx_prev_n = 0;
        for (int k = 0; k < n; k++) begin
            d = rnd128();
            rx_valid_i = 1'b1; rx_hdr_i = 1'b0; rx_flit_i = d;
            @(negedge clk);
            chk(!rx_crc_error_o, "R8 no pulse on data", 128'(rx_crc_error_o), '0);
            if (k < 2) begin
                rx_prev[k] = d;
                rx_prev_n  = k + 1;
            end
        end
        rx_valid_i = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset("R1 reset state");
        idle_cycle("R1 after reset");
        tx_txn(2, 1'b0, 1'b0, "R1 first header null previous");

        // all pairings of previous/current payload counts
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                tx_txn(a, 1'b0, 1'b0, "R2 R3 R6 R7 header crc");
                tx_txn(b, (a == b), 1'b0, "R2 R6 R7 R11 header crc");
            end
        end
        tx_txn(0, 1'b0, 1'b1, "R4 low field ignored");
        tx_txn(1, 1'b0, 1'b1, "R4 low field ignored");
        tx_txn(3, 1'b0, 1'b1, "R4 R6 low field ignored");
        tx_txn(0, 1'b0, 1'b0, "R6 extra flit ignored");
        idle_cycle("R11 idle");

        // reset mid-stream on transmit side
        tx_txn(2, 1'b0, 1'b0, "R2 before reset");
        do_reset("R10 reset mid-stream");
        tx_txn(0, 1'b0, 1'b0, "R10 null previous after reset");

        // receive side
        rx_txn(2, -1, 1'b0, "R8 matching header");
        rx_txn(1, -1, 1'b0, "R8 R9 matching header");
        for (int f = 0; f < 25; f++) begin
            rx_txn(f % 4, f, 1'b0, "R8 flipped crc bit");
            idle_cycle("R8 one-cycle pulse");
        end
        rx_txn(2, -1, 1'b0, "R9 setup");
        rx_txn(0, -1, 1'b1, "R9 payload omitted");
        rx_txn(0, -1, 1'b1, "R7 R9 empty previous ok");
        rx_txn(3, -1, 1'b0, "R9 setup three flits");
        rx_txn(0, -1, 1'b0, "R6 R9 third flit ignored");
        rx_txn(2, -1, 1'b0, "R9 setup");
        do_reset("R10 reset mid-stream rx");
        rx_txn(0, -1, 1'b1, "R10 null previous rx");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule